// File: doc/BRIEF.md
# Reservation Station Pool

This block keeps a handful of decoded instructions waiting in front of a single functional unit until their operands exist. The dispatch stage writes an instruction into any free slot, together with its opcode, its destination tag and two source operands. A source that is already known arrives with its value. A source that is still being computed arrives as a tag only. A result bus carries finished values with their tags, and every waiting source with that tag picks up the value.

Slots are not kept in arrival order. In each cycle, the lowest-numbered slot whose two sources are both present is offered to the functional unit. The offer is taken when the unit signals that it can accept. A slot that issues becomes free at that clock edge. A new dispatch always fills the lowest-numbered slot that was free before the edge.

Top module: `rs_pool`

## Requirements
- R1: While reset is asserted and on the first cycle after it, no slot is occupied: `iss_valid` is 0 and `disp_ready` is 1.
- R2: A dispatch is accepted on a clock edge where `disp_valid` and `disp_ready` are both 1, and the slot then holds the given opcode and destination tag.
- R3: A source dispatched with its available flag set is stored as present and keeps the dispatched value.
- R4: A result broadcast (`bc_valid` = 1) whose tag equals the tag of a waiting, not-yet-present source of an occupied slot stores `bc_data` into that source and marks it present. Sources with other tags are left untouched.
- R5: A broadcast in the same cycle as a dispatch is also captured by the slot being written, for any source dispatched without its available flag whose tag matches.
- R6: `iss_valid` is 1 exactly when some occupied slot has both sources present. A source that becomes present at an edge counts from the next cycle on.
- R7: When several slots are ready, the issue outputs (`iss_op`, `iss_dst`, `iss_s1_data`, `iss_s2_data`) show the lowest-numbered ready slot, whatever the order of arrival.
- R8: An accepted dispatch is written into the lowest-numbered slot that was free before the clock edge.
- R9: When `iss_valid` and `iss_ready` are both 1, the offered slot is freed at that edge. While `iss_ready` is 0, a ready slot stays occupied and ready.
- R10: `disp_ready` is 0 when every slot is occupied, and a dispatch offered in such a cycle changes nothing.
- R11: A broadcast whose tag matches a source that is already present does not overwrite that source's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| disp_valid | input | 1 | Dispatch offers an instruction |
| disp_ready | output | 1 | At least one slot is free |
| disp_op | input | OP_W | Opcode of the dispatched instruction |
| disp_dst | input | TAG_W | Destination tag |
| disp_s1_tag | input | TAG_W | Tag of source 1 |
| disp_s1_data | input | DATA_W | Value of source 1 when available |
| disp_s1_ok | input | 1 | Source 1 value is available at dispatch |
| disp_s2_tag | input | TAG_W | Tag of source 2 |
| disp_s2_data | input | DATA_W | Value of source 2 when available |
| disp_s2_ok | input | 1 | Source 2 value is available at dispatch |
| bc_valid | input | 1 | A result is broadcast this cycle |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_data | input | DATA_W | Value of the broadcast result |
| iss_valid | output | 1 | A ready instruction is offered to the unit |
| iss_ready | input | 1 | The unit accepts the offer |
| iss_op | output | OP_W | Opcode of the offered instruction |
| iss_dst | output | TAG_W | Destination tag of the offered instruction |
| iss_s1_data | output | DATA_W | Source 1 value of the offered instruction |
| iss_s2_data | output | DATA_W | Source 2 value of the offered instruction |

## Verification
The bench builds the pool with its default parameters: four slots, 4-bit tags, 16-bit data and 5-bit opcodes. Four slots let a short directed sequence fill the pool and test a refused dispatch, and a drain then shows that issue order follows slot number. The 4-bit tag space is small, so random tags in broadcasts often match waiting sources, already-present sources, and instructions being dispatched in the same cycle. This exercises the capture corner cases many times.

// File: rtl/rs_pool_pkg.sv
package rs_pool_pkg;
  localparam int RS_DEF_ENTRIES = 4;
  localparam int RS_DEF_OP_W    = 5;
  localparam int RS_DEF_TAG_W   = 4;
  localparam int RS_DEF_DATA_W  = 16;
  localparam int RS_NUM_SRC     = 2;

  typedef enum logic {
    SLOT_IDLE = 1'b0,
    SLOT_HELD = 1'b1
  } slot_st_e;
endpackage

// File: rtl/rs_lowest.sv
module rs_lowest #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  // lowest set bit isolated by two's complement
  assign gnt = req & (~req + N'(1));
  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/rs_operand.sv
module rs_operand #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              ld,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_ok,
  input  logic              watch,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              ok,
  output logic [DATA_W-1:0] data
);
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] data_q, data_n;
  logic              ok_q, ok_n;
  logic              hit_ld, hit_wait, en;

  assign hit_ld   = bc_valid && (bc_tag == ld_tag);
  assign hit_wait = bc_valid && (bc_tag == tag_q) && watch && !ok_q;
  assign en       = ld || hit_wait;

  always_comb begin
    if (ld) begin
      ok_n   = ld_ok || hit_ld;
      data_n = ld_ok ? ld_data : bc_data;
    end else begin
      ok_n   = 1'b1;
      data_n = bc_data;
    end
  end

  always_ff @(posedge clk) begin
    if (ld) tag_q <= ld_tag;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      ok_q   <= ok_n;
      data_q <= data_n;
    end
  end

  assign ok   = ok_q;
  assign data = data_q;
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pool_pkg::*;
#(
  parameter int OP_W   = 5,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ld,
  input  logic                                clr,
  input  logic [OP_W-1:0]                     ld_op,
  input  logic [TAG_W-1:0]                    ld_dst,
  input  logic [RS_NUM_SRC-1:0][TAG_W-1:0]    ld_tag,
  input  logic [RS_NUM_SRC-1:0][DATA_W-1:0]   ld_data,
  input  logic [RS_NUM_SRC-1:0]               ld_ok,
  input  logic                                bc_valid,
  input  logic [TAG_W-1:0]                    bc_tag,
  input  logic [DATA_W-1:0]                   bc_data,
  output logic                                held,
  output logic                                rdy,
  output logic [OP_W-1:0]                     op,
  output logic [TAG_W-1:0]                    dst,
  output logic [RS_NUM_SRC-1:0][DATA_W-1:0]   src_data
);
  slot_st_e st_q, st_n;
  logic     st_en;
  logic [OP_W-1:0]       op_q;
  logic [TAG_W-1:0]      dst_q;
  logic [RS_NUM_SRC-1:0] src_ok;

  assign st_en = ld || clr;

  always_comb begin
    st_n = st_q;
    if (clr)     st_n = SLOT_IDLE;
    else if (ld) st_n = SLOT_HELD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= SLOT_IDLE;
    else if (st_en) st_q <= st_n;
  end

  always_ff @(posedge clk) begin
    if (ld) begin
      op_q  <= ld_op;
      dst_q <= ld_dst;
    end
  end

  for (genvar k = 0; k < RS_NUM_SRC; k++) begin : g_src
    rs_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_opnd (
      .clk     (clk),
      .ld      (ld),
      .ld_tag  (ld_tag[k]),
      .ld_data (ld_data[k]),
      .ld_ok   (ld_ok[k]),
      .watch   (st_q == SLOT_HELD),
      .bc_valid(bc_valid),
      .bc_tag  (bc_tag),
      .bc_data (bc_data),
      .ok      (src_ok[k]),
      .data    (src_data[k])
    );
  end

  assign held = (st_q == SLOT_HELD);
  assign rdy  = held && (&src_ok);
  assign op   = op_q;
  assign dst  = dst_q;
endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pool_pkg::*;
#(
  parameter int ENTRIES = RS_DEF_ENTRIES,
  parameter int OP_W    = RS_DEF_OP_W,
  parameter int TAG_W   = RS_DEF_TAG_W,
  parameter int DATA_W  = RS_DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic [OP_W-1:0]   disp_op,
  input  logic [TAG_W-1:0]  disp_dst,
  input  logic [TAG_W-1:0]  disp_s1_tag,
  input  logic [DATA_W-1:0] disp_s1_data,
  input  logic              disp_s1_ok,
  input  logic [TAG_W-1:0]  disp_s2_tag,
  input  logic [DATA_W-1:0] disp_s2_data,
  input  logic              disp_s2_ok,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [OP_W-1:0]   iss_op,
  output logic [TAG_W-1:0]  iss_dst,
  output logic [DATA_W-1:0] iss_s1_data,
  output logic [DATA_W-1:0] iss_s2_data
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] busy_vec, rdy_vec, load_vec, clr_vec;
  logic [ENTRIES-1:0] iss_gnt, free_gnt;
  logic [IW-1:0]      iss_idx, free_idx;
  logic               iss_any, free_any, disp_fire, iss_fire;

  logic [OP_W-1:0]                           e_op  [ENTRIES];
  logic [TAG_W-1:0]                          e_dst [ENTRIES];
  logic [RS_NUM_SRC-1:0][DATA_W-1:0]         e_src [ENTRIES];

  logic [RS_NUM_SRC-1:0][TAG_W-1:0]  in_tag;
  logic [RS_NUM_SRC-1:0][DATA_W-1:0] in_data;
  logic [RS_NUM_SRC-1:0]             in_ok;

  assign in_tag  = {disp_s2_tag,  disp_s1_tag};
  assign in_data = {disp_s2_data, disp_s1_data};
  assign in_ok   = {disp_s2_ok,   disp_s1_ok};

  rs_lowest #(.N(ENTRIES)) u_free_pick (
    .req(~busy_vec), .gnt(free_gnt), .idx(free_idx), .any(free_any)
  );

  rs_lowest #(.N(ENTRIES)) u_iss_pick (
    .req(rdy_vec), .gnt(iss_gnt), .idx(iss_idx), .any(iss_any)
  );

  assign disp_ready = free_any;
  assign disp_fire  = disp_valid && free_any;
  assign iss_valid  = iss_any;
  assign iss_fire   = iss_any && iss_ready;
  assign load_vec   = free_gnt & {ENTRIES{disp_fire}};
  assign clr_vec    = iss_gnt  & {ENTRIES{iss_fire}};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    rs_entry #(.OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (load_vec[e]),
      .clr     (clr_vec[e]),
      .ld_op   (disp_op),
      .ld_dst  (disp_dst),
      .ld_tag  (in_tag),
      .ld_data (in_data),
      .ld_ok   (in_ok),
      .bc_valid(bc_valid),
      .bc_tag  (bc_tag),
      .bc_data (bc_data),
      .held    (busy_vec[e]),
      .rdy     (rdy_vec[e]),
      .op      (e_op[e]),
      .dst     (e_dst[e]),
      .src_data(e_src[e])
    );
  end

  assign iss_op      = e_op[iss_idx];
  assign iss_dst     = e_dst[iss_idx];
  assign iss_s1_data = e_src[iss_idx][0];
  assign iss_s2_data = e_src[iss_idx][1];

  // free_idx kept for visibility in waveforms of higher levels
  logic unused_ok;
  assign unused_ok = ^free_idx;
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         disp_valid,
  input logic         disp_ready,
  input logic         iss_valid,
  input logic         iss_ready,
  input logic [N-1:0] busy,
  input logic [N-1:0] iss_gnt,
  input logic [N-1:0] load
);
  p_rst_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (busy == '0));

  p_accept_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && !(iss_valid && iss_ready))
      |=> ($countones(busy) == $past($countones(busy)) + 1));

  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> iss_valid);

  p_load_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load) && ((load & busy) == '0));

  p_issue_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> ((busy & $past(iss_gnt)) == '0));

  p_full_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy) |-> !disp_ready);
endmodule

bind rs_pool rs_pool_chk #(.N(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .disp_valid(disp_valid),
  .disp_ready(disp_ready),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .busy      (busy_vec),
  .iss_gnt   (iss_gnt),
  .load      (load_vec)
);

// File: tb/rs_pool_tb.sv
module rs_pool_tb;
  localparam int N = 4, OW = 5, TW = 4, DW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, disp_valid, disp_ready, disp_s1_ok, disp_s2_ok;
  logic [OW-1:0] disp_op;
  logic [TW-1:0] disp_dst, disp_s1_tag, disp_s2_tag, bc_tag, iss_dst;
  logic [DW-1:0] disp_s1_data, disp_s2_data, bc_data, iss_s1_data, iss_s2_data;
  logic bc_valid, iss_valid, iss_ready;
  logic [OW-1:0] iss_op;

  rs_pool #(.ENTRIES(N), .OP_W(OW), .TAG_W(TW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
    .disp_dst(disp_dst), .disp_s1_tag(disp_s1_tag), .disp_s1_data(disp_s1_data),
    .disp_s1_ok(disp_s1_ok), .disp_s2_tag(disp_s2_tag), .disp_s2_data(disp_s2_data),
    .disp_s2_ok(disp_s2_ok), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op), .iss_dst(iss_dst),
    .iss_s1_data(iss_s1_data), .iss_s2_data(iss_s2_data)
  );

  int checks = 0, fails = 0;
  string cur_req = "R1";

  // behavioural reference: one record per slot
  bit m_busy[N];
  bit m_v1[N], m_v2[N];
  int m_op[N], m_dst[N], m_t1[N], m_t2[N], m_d1[N], m_d2[N];

  function automatic int first_ready();
    for (int i = 0; i < N; i++) if (m_busy[i] && m_v1[i] && m_v2[i]) return i;
    return -1;
  endfunction

  function automatic int first_free();
    for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
    return -1;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle_in();
    disp_valid = 0; disp_op = '0; disp_dst = '0;
    disp_s1_tag = '0; disp_s1_data = '0; disp_s1_ok = 0;
    disp_s2_tag = '0; disp_s2_data = '0; disp_s2_ok = 0;
    bc_valid = 0; bc_tag = '0; bc_data = '0;
  endtask

  task automatic set_disp(int op, int dst, int t1, int d1, bit ok1, int t2, int d2, bit ok2);
    disp_valid = 1; disp_op = OW'(op); disp_dst = TW'(dst);
    disp_s1_tag = TW'(t1); disp_s1_data = DW'(d1); disp_s1_ok = ok1;
    disp_s2_tag = TW'(t2); disp_s2_data = DW'(d2); disp_s2_ok = ok2;
  endtask

  task automatic set_bc(int tag, int data);
    bc_valid = 1; bc_tag = TW'(tag); bc_data = DW'(data);
  endtask

  // compare outputs, advance the model, cross one clock edge
  task automatic cycle();
    int r, f;
    bit hit;
    #1;
    r = first_ready();
    f = first_free();
    chk({cur_req, "/R10"}, "disp_ready", int'(disp_ready), int'(f >= 0));
    chk({cur_req, "/R6"}, "iss_valid", int'(iss_valid), int'(r >= 0));
    if (r >= 0 && iss_valid === 1'b1) begin
      chk({cur_req, "/R7"}, "iss_op", int'(iss_op), m_op[r]);
      chk({cur_req, "/R7"}, "iss_dst", int'(iss_dst), m_dst[r]);
      chk({cur_req, "/R4"}, "iss_s1_data", int'(iss_s1_data), m_d1[r]);
      chk({cur_req, "/R4"}, "iss_s2_data", int'(iss_s2_data), m_d2[r]);
    end
    if (bc_valid) begin
      for (int i = 0; i < N; i++) begin
        if (m_busy[i] && !m_v1[i] && m_t1[i] == int'(bc_tag)) begin m_v1[i] = 1; m_d1[i] = int'(bc_data); end
        if (m_busy[i] && !m_v2[i] && m_t2[i] == int'(bc_tag)) begin m_v2[i] = 1; m_d2[i] = int'(bc_data); end
      end
    end
    if (r >= 0 && iss_ready) m_busy[r] = 0;
    if (disp_valid && f >= 0) begin
      m_busy[f] = 1; m_op[f] = int'(disp_op); m_dst[f] = int'(disp_dst);
      m_t1[f] = int'(disp_s1_tag); m_t2[f] = int'(disp_s2_tag);
      hit = bc_valid && (bc_tag == disp_s1_tag);
      m_v1[f] = disp_s1_ok || hit;
      m_d1[f] = disp_s1_ok ? int'(disp_s1_data) : int'(bc_data);
      hit = bc_valid && (bc_tag == disp_s2_tag);
      m_v2[f] = disp_s2_ok || hit;
      m_d2[f] = disp_s2_ok ? int'(disp_s2_data) : int'(bc_data);
    end
    @(posedge clk);
    @(negedge clk);
    idle_in();
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; iss_ready = 0; idle_in();
    for (int i = 0; i < N; i++) m_busy[i] = 0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", "iss_valid in reset", int'(iss_valid), 0);
    chk("R1", "disp_ready in reset", int'(disp_ready), 1);
    rst_n = 1;
    cycle();

    // R2 R3: both sources known at dispatch, issue next cycle
    cur_req = "R2/R3";
    set_disp(3, 7, 1, 'h11, 1, 2, 'h22, 1); cycle();
    cycle();
    iss_ready = 1; cycle();
    iss_ready = 0; cycle();

    // R10: fill all slots with waiting sources, then a refused dispatch
    cur_req = "R10";
    set_disp(1, 10, 1, 0, 0, 2, 0, 0); cycle();
    set_disp(2, 11, 3, 0, 0, 4, 0, 0); cycle();
    set_disp(4, 12, 5, 0, 0, 6, 0, 0); cycle();
    set_disp(8, 13, 7, 0, 0, 8, 0, 0); cycle();
    set_disp(9, 14, 0, 'h55, 1, 0, 'h66, 1); cycle();
    cycle();

    // R4 R7: slot 3 then slot 1 become ready; lowest index offered
    cur_req = "R4/R7";
    set_bc(7, 'hAAAA); cycle();
    set_bc(8, 'hBBBB); cycle();
    set_bc(3, 'h3333); cycle();
    set_bc(4, 'h4444); cycle();
    // R11: repeated tag on a present source must not overwrite
    cur_req = "R11";
    set_bc(7, 'hDEAD); cycle();
    cycle();

    // R9: drain with the unit accepting
    cur_req = "R9";
    iss_ready = 1; cycle();
    cycle();
    set_bc(1, 'h0101); cycle();
    set_bc(2, 'h0202); cycle();
    set_bc(5, 'h0505); cycle();
    set_bc(6, 'h0606); cycle();
    cycle(); cycle();
    iss_ready = 0;

    // R5: broadcast captured by the instruction dispatched in the same cycle
    cur_req = "R5";
    set_disp(6, 3, 9, 0, 0, 9, 0, 0); set_bc(9, 'h9999); cycle();
    cycle();
    iss_ready = 1; cycle();
    cycle();

    // R8: random traffic, slot order shows through issue priority
    cur_req = "R8";
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 2 == 0)
        set_disp($urandom % 32, $urandom % 16, $urandom % 16, $urandom % 65536,
                 ($urandom % 3 == 0), $urandom % 16, $urandom % 65536, ($urandom % 3 == 0));
      if ($urandom % 3 != 0) set_bc($urandom % 16, $urandom % 65536);
      iss_ready = ($urandom % 4 != 0);
      cycle();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule